// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block is a non-blocking time-slot interchanger. It handles eight serial input streams and eight serial output streams. Each stream carries a frame of 32 eight-bit channels, and each bit takes one period of `clk`, which is the bit clock. Every input channel is turned into a byte and stored in a data memory. The write position comes from a frame counter that the frame pulse restarts.

Every output stream/channel pair has one connect-memory entry. The entry is either a source address (connection mode) or a literal byte (message mode), together with a per-channel drive-enable flag. A global message-enable input forces every channel into message mode with its drive enabled. A global active-low output-disable input stops every output from driving.

Each output byte is fetched one channel-time early, at the last bit of the previous channel, and is then shifted out most significant bit first. Tri-state is shown as a per-stream drive-enable (`ser_oe`) next to the data (`ser_out`), and a stream that is not driving holds `ser_out` low.

Top module: `tsi_switch`

## Requirements
- R1: After reset every connect-memory entry reads as zero, so with `out_disable_n` high all `ser_oe` and `ser_out` stay low until entries are written.
- R2: In connection mode (message flag clear, enable flag set), output stream o, channel c carries the byte received on the source named by the entry's low byte. Bits [7:5] of the low byte give the source stream and bits [4:0] give the source channel.
- R3: The byte for output channel c is fetched at the end of the last bit of channel c-1 (channel 31 of the previous frame when c is 0). A source byte received in channel ci of the same frame is seen only if ci <= c-2. Otherwise the previous frame's byte is sent, and for c=0 with ci=31 the byte from two frames back is sent.
- R4: Any number of output channels may name the same source, and each of them carries that source's byte (broadcast).
- R5: When an entry's message flag is set, its low byte is transmitted on that output channel in every frame.
- R6: When an entry's enable flag is clear and global message-enable is low, that output channel has `ser_oe` low and `ser_out` low for all eight bits. Other channels are not affected.
- R7: While `out_disable_n` is low, all `ser_oe` and `ser_out` bits are low in that same cycle. When it is high, the per-channel enable applies.
- R8: While `msg_all` is high at fetch time, every output channel sends its low byte with its drive enabled, whatever its stored message and enable flags.
- R9: Serial bytes are sent and received most significant bit first, one bit per clock. The cycle in which `frame_pulse` is high carries channel 0 bit 7 on both inputs and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | High in the cycle of channel 0 bit 7 |
| ser_in | input | 8 | Serial input streams |
| out_disable_n | input | 1 | Low forces every output to stop driving |
| msg_all | input | 1 | Global message-enable override |
| cm_wr_en | input | 1 | Connect-memory write strobe |
| cm_wr_stream | input | 3 | Output stream of the entry being written |
| cm_wr_chan | input | 5 | Output channel of the entry being written |
| cm_wr_msg | input | 1 | Message-mode flag to store |
| cm_wr_oe | input | 1 | Per-channel drive-enable flag to store |
| cm_wr_low | input | 8 | Source address {stream, channel} or message byte |
| ser_out | output | 8 | Serial output data, low when not driving |
| ser_oe | output | 8 | Per-stream drive enable for the current bit |

## Verification
The assertions assume that, after its first appearance, `frame_pulse` arrives exactly one frame (256 cycles) after the previous one. Several checks also assume the frame counter stays aligned, so a channel boundary always lands on a multiple of eight bits. The stimulus drives the pulse at a fixed period and never skips or moves it. Connect-memory contents and `msg_all` change only in frames that are not checked, and one full settling frame follows each change, so no check depends on a fetch racing a write.

// File: rtl/tsi_pkg.sv
// Package: shared constants and the connect-memory entry type for the
// time-slot interchange switch. Assumes eight-bit channels.
package tsi_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    // One connect-memory location: mode flag, drive flag, low byte.
    typedef struct packed {
        logic              msg;
        logic              oe;
        logic [BYTE_W-1:0] low;
    } cm_entry_t;

endpackage

// File: rtl/tsi_timing.sv
// Frame timing: keeps the bit position within the frame. The frame pulse
// forces position 0 (channel 0, first bit). Without a pulse the counter
// wraps on its own at the end of the frame.
// Assumes NUM_CHANNELS is a power of two.
module tsi_timing
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_CHANNELS = 32,
    localparam int unsigned CW = $clog2(NUM_CHANNELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    output logic [CW-1:0]    cur_chan,
    output logic [BIT_W-1:0] cur_bit,
    output logic             chan_last,
    output logic [CW-1:0]    next_chan
);

    localparam int unsigned FRAME_BITS = NUM_CHANNELS * BYTE_W;
    localparam int unsigned PW         = $clog2(FRAME_BITS);
    localparam logic [PW-1:0] LAST_POS = PW'(FRAME_BITS - 1);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] cur_pos;
    logic          started_q;

    // Position of the current cycle: restart on the pulse, otherwise advance and wrap.
    always_comb begin
        if (frame_pulse || pos_q == LAST_POS) begin
            cur_pos = '0;
        end else begin
            cur_pos = pos_q + 1'b1;
        end
    end

    // Keep the position of the previous cycle and note the first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q     <= LAST_POS;
            started_q <= 1'b0;
        end else begin
            pos_q <= cur_pos;
            if (frame_pulse) begin
                started_q <= 1'b1;
            end
        end
    end

    assign cur_chan  = cur_pos[PW-1:BIT_W];
    assign cur_bit   = cur_pos[BIT_W-1:0];
    assign chan_last = (cur_bit == BIT_W'(BYTE_W - 1));
    assign next_chan = cur_chan + 1'b1;

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && frame_pulse) |-> (pos_q == LAST_POS)); // R9

endmodule

// File: rtl/tsi_rx.sv
// Receive side: shifts in each input stream MSB first and writes the
// complete byte into the data memory at {stream, channel} on the last bit
// of the channel. Has one combinational read port per output stream.
// The data memory has no reset; its contents are valid once a frame has been received.
module tsi_rx
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS  = 8,
    parameter int unsigned NUM_CHANNELS = 32,
    localparam int unsigned SW = $clog2(NUM_STREAMS),
    localparam int unsigned CW = $clog2(NUM_CHANNELS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_STREAMS-1:0]              ser_in,
    input  logic [CW-1:0]                       cur_chan,
    input  logic                                chan_last,
    input  logic [NUM_STREAMS-1:0][SW-1:0]      rd_stream,
    input  logic [NUM_STREAMS-1:0][CW-1:0]      rd_chan,
    output logic [NUM_STREAMS-1:0][BYTE_W-1:0]  rd_data
);

    logic [NUM_STREAMS-1:0][BYTE_W-2:0] sh_q;
    logic [BYTE_W-1:0]                  dmem [NUM_STREAMS][NUM_CHANNELS];

    // Collect the leading bits of each stream's current channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                sh_q[s] <= {sh_q[s][BYTE_W-3:0], ser_in[s]};
            end
        end
    end

    // Store each completed byte at its stream and channel.
    always_ff @(posedge clk) begin
        if (chan_last) begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                dmem[s][cur_chan] <= {sh_q[s], ser_in[s]};
            end
        end
    end

    for (genvar r = 0; r < NUM_STREAMS; r++) begin : g_rd
        // Switched read for output stream r.
        assign rd_data[r] = dmem[rd_stream[r]][rd_chan[r]];

        AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            chan_last |=> (dmem[r][$past(cur_chan)] == $past({sh_q[r], ser_in[r]}))); // R9
    end

endmodule

// File: rtl/tsi_cm.sv
// Connect memory: one entry per output stream and channel, cleared by
// reset. Single write port. For every output stream it reads the entry of
// the channel to be fetched next.
module tsi_cm
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS  = 8,
    parameter int unsigned NUM_CHANNELS = 32,
    localparam int unsigned SW = $clog2(NUM_STREAMS),
    localparam int unsigned CW = $clog2(NUM_CHANNELS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [SW-1:0]                     wr_stream,
    input  logic [CW-1:0]                     wr_chan,
    input  cm_entry_t                         wr_entry,
    input  logic [CW-1:0]                     rd_chan,
    output cm_entry_t [NUM_STREAMS-1:0]       rd_entry
);

    localparam int unsigned DEPTH = NUM_STREAMS * NUM_CHANNELS;

    cm_entry_t cm_q [DEPTH];

    // Clear on reset, then accept writes from the control side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cm_q[i] <= '0;
            end
        end else if (wr_en) begin
            cm_q[{wr_stream, wr_chan}] <= wr_entry;
        end
    end

    for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_rd
        // Entry of the next channel on output stream o.
        assign rd_entry[o] = cm_q[{SW'(o), rd_chan}];
    end

    AST_CM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_entry == '0)); // R1

endmodule

// File: rtl/tsi_tx.sv
// Transmit side: on the last bit of each channel, loads every output
// stream's next byte and drive flag. The byte is the message byte or the
// switched byte, and msg_all forces message mode with the drive enabled.
// The byte is sent MSB first. out_disable_n gates the drive in the same cycle.
module tsi_tx
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                chan_last,
    input  logic [BIT_W-1:0]                    cur_bit,
    input  logic                                msg_all,
    input  logic                                out_disable_n,
    input  cm_entry_t [NUM_STREAMS-1:0]         cm_rd,
    input  logic [NUM_STREAMS-1:0][BYTE_W-1:0]  sw_data,
    output logic [NUM_STREAMS-1:0]              ser_out,
    output logic [NUM_STREAMS-1:0]              ser_oe
);

    localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

    logic [NUM_STREAMS-1:0][BYTE_W-1:0] byte_q;
    logic [NUM_STREAMS-1:0]             en_q;
    logic [BIT_W-1:0]                   bit_idx;

    // Fetch the next channel's byte and drive flag one channel early.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            en_q   <= '0;
        end else if (chan_last) begin
            for (int o = 0; o < NUM_STREAMS; o++) begin
                en_q[o]   <= msg_all | cm_rd[o].oe;
                byte_q[o] <= (msg_all | cm_rd[o].msg) ? cm_rd[o].low : sw_data[o];
            end
        end
    end

    // Bit being sent this cycle, most significant first.
    assign bit_idx = TOP_BIT - cur_bit;

    for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_out
        // Drive gating and serial data for stream o.
        assign ser_oe[o]  = en_q[o] & out_disable_n;
        assign ser_out[o] = ser_oe[o] & byte_q[o][bit_idx];
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ser_oe == '0)); // R1
    AST_EN_STABLE_IN_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_last |=> $stable(en_q)); // R6
    AST_MSG_ALL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_last && msg_all) |=> (&en_q)); // R8

endmodule

// File: rtl/tsi_switch.sv
// Top of the time-slot interchange switch. Connects frame timing, receive
// data memory, connect memory and transmit serializers. The low byte of a
// connection-mode entry is {source stream, source channel}.
// Assumes NUM_STREAMS and NUM_CHANNELS are powers of two and that the
// source address fits in the low byte.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned NUM_STREAMS  = 8,
    parameter int unsigned NUM_CHANNELS = 32,
    localparam int unsigned SW = $clog2(NUM_STREAMS),
    localparam int unsigned CW = $clog2(NUM_CHANNELS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_pulse,
    input  logic [NUM_STREAMS-1:0] ser_in,
    input  logic                   out_disable_n,
    input  logic                   msg_all,
    input  logic                   cm_wr_en,
    input  logic [SW-1:0]          cm_wr_stream,
    input  logic [CW-1:0]          cm_wr_chan,
    input  logic                   cm_wr_msg,
    input  logic                   cm_wr_oe,
    input  logic [BYTE_W-1:0]      cm_wr_low,
    output logic [NUM_STREAMS-1:0] ser_out,
    output logic [NUM_STREAMS-1:0] ser_oe
);

    logic [CW-1:0]                      cur_chan;
    logic [CW-1:0]                      next_chan;
    logic [BIT_W-1:0]                   cur_bit;
    logic                               chan_last;
    cm_entry_t                          wr_entry;
    cm_entry_t [NUM_STREAMS-1:0]        cm_rd;
    logic [NUM_STREAMS-1:0][SW-1:0]     src_stream;
    logic [NUM_STREAMS-1:0][CW-1:0]     src_chan;
    logic [NUM_STREAMS-1:0][BYTE_W-1:0] sw_data;

    // Pack the write fields into one entry.
    assign wr_entry = '{msg: cm_wr_msg, oe: cm_wr_oe, low: cm_wr_low};

    for (genvar o = 0; o < NUM_STREAMS; o++) begin : g_src
        // Source address fields for output stream o.
        assign src_stream[o] = cm_rd[o].low[SW+CW-1:CW];
        assign src_chan[o]   = cm_rd[o].low[CW-1:0];
    end

    tsi_timing #(.NUM_CHANNELS(NUM_CHANNELS)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .cur_chan   (cur_chan),
        .cur_bit    (cur_bit),
        .chan_last  (chan_last),
        .next_chan  (next_chan)
    );

    tsi_rx #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_in   (ser_in),
        .cur_chan (cur_chan),
        .chan_last(chan_last),
        .rd_stream(src_stream),
        .rd_chan  (src_chan),
        .rd_data  (sw_data)
    );

    tsi_cm #(.NUM_STREAMS(NUM_STREAMS), .NUM_CHANNELS(NUM_CHANNELS)) u_cm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cm_wr_en),
        .wr_stream(cm_wr_stream),
        .wr_chan  (cm_wr_chan),
        .wr_entry (wr_entry),
        .rd_chan  (next_chan),
        .rd_entry (cm_rd)
    );

    tsi_tx #(.NUM_STREAMS(NUM_STREAMS)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_last    (chan_last),
        .cur_bit      (cur_bit),
        .msg_all      (msg_all),
        .out_disable_n(out_disable_n),
        .cm_rd        (cm_rd),
        .sw_data      (sw_data),
        .ser_out      (ser_out),
        .ser_oe       (ser_oe)
    );

endmodule

// File: tb/tb_tsi_switch.sv
// Bench for tsi_switch: random channel data and connect-memory contents
// from a fixed seed, plus directed corner cases. Every output bit is checked
// against a model built from the requirements.
module tb_tsi_switch;

    localparam int NS = 8;
    localparam int NC = 32;
    localparam int FB = NC * 8;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic [NS-1:0] ser_in = '0;
    logic          out_disable_n = 1'b1;
    logic          msg_all = 1'b0;
    logic          cm_wr_en = 1'b0;
    logic [2:0]    cm_wr_stream = '0;
    logic [4:0]    cm_wr_chan = '0;
    logic          cm_wr_msg = 1'b0;
    logic          cm_wr_oe = 1'b0;
    logic [7:0]    cm_wr_low = '0;
    logic [NS-1:0] ser_out;
    logic [NS-1:0] ser_oe;

    always #4 clk = ~clk;

    tsi_switch dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .ser_in(ser_in),
        .out_disable_n(out_disable_n), .msg_all(msg_all), .cm_wr_en(cm_wr_en),
        .cm_wr_stream(cm_wr_stream), .cm_wr_chan(cm_wr_chan), .cm_wr_msg(cm_wr_msg),
        .cm_wr_oe(cm_wr_oe), .cm_wr_low(cm_wr_low), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    int checks = 0;
    int fails = 0;
    int bpos = 0;
    int fr = 0;
    bit chk_en = 0;
    bit rand_dis = 0;
    bit done = 0;
    string tag = "R1";

    logic [7:0] hist [4][NS][NC];
    logic       sh_msg [NS*NC];
    logic       sh_oe  [NS*NC];
    logic [7:0] sh_low [NS*NC];
    logic [7:0] exp_byte [NS];
    logic       exp_en [NS];

    // Source byte seen by output channel c under the fetch-freshness rule (R3).
    function automatic logic [7:0] src_byte(int si, int ci, int c);
        if (ci + 2 <= c)            return hist[fr % 4][si][ci];
        else if (c == 0 && ci == 31) return hist[(fr + 2) % 4][si][ci];
        else                        return hist[(fr + 3) % 4][si][ci];
    endfunction

    // One bit period: drive inputs, model, compare outputs, advance.
    task automatic tick();
        int c = bpos / 8;
        int k = bpos % 8;
        if (k == 0) begin
            for (int s = 0; s < NS; s++) hist[fr % 4][s][c] = 8'($urandom);
            for (int o = 0; o < NS; o++) begin
                int idx = o * NC + c;
                bit m = msg_all | sh_msg[idx];
                exp_en[o]   = msg_all | sh_oe[idx];
                exp_byte[o] = m ? sh_low[idx]
                                : src_byte(int'(sh_low[idx][7:5]), int'(sh_low[idx][4:0]), c);
            end
        end
        frame_pulse = (bpos == 0);
        for (int s = 0; s < NS; s++) ser_in[s] = hist[fr % 4][s][c][7-k];
        if (rand_dis) out_disable_n = 1'($urandom);
        #1;
        if (chk_en) begin
            for (int o = 0; o < NS; o++) begin
                logic eoe = exp_en[o] & out_disable_n;
                logic eout = eoe & exp_byte[o][7-k];
                checks++;
                if (ser_oe[o] !== eoe || ser_out[o] !== eout) begin
                    fails++;
                    $display("FAIL %s stream %0d chan %0d bit %0d: oe/out=%b%b expected %b%b",
                             tag, o, c, 7-k, ser_oe[o], ser_out[o], eoe, eout);
                end
            end
        end
        bpos++;
        if (bpos == FB) begin
            bpos = 0;
            fr++;
        end
        @(negedge clk);
    endtask

    task automatic run_frames(int n);
        repeat (n * FB) tick();
    endtask

    // Write one connect-memory entry and its shadow copy.
    task automatic cm_write(int o, int c, bit m, bit e, logic [7:0] low);
        cm_wr_en = 1'b1; cm_wr_stream = 3'(o); cm_wr_chan = 5'(c);
        cm_wr_msg = m; cm_wr_oe = e; cm_wr_low = low;
        sh_msg[o*NC+c] = m; sh_oe[o*NC+c] = e; sh_low[o*NC+c] = low;
        tick();
        cm_wr_en = 1'b0;
    endtask

    // Unchecked settling frame, then n checked frames under a tag.
    task automatic check_frames(string t, int n);
        chk_en = 0;
        run_frames(1);
        tag = t;
        chk_en = 1;
        run_frames(n);
        chk_en = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS*NC; i++) begin
            sh_msg[i] = 0; sh_oe[i] = 0; sh_low[i] = '0;
        end
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++) hist[f][s][c] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing drives while the connect memory is clear.
        tag = "R1"; chk_en = 1;
        run_frames(1);
        chk_en = 0;

        // R2: random connection map, all channels enabled.
        for (int i = 0; i < NS*NC; i++) cm_write(i / NC, i % NC, 0, 1, 8'($urandom));
        check_frames("R2", 3);

        // R3: directed freshness corners on output stream 0.
        cm_write(0, 5, 0, 1, {3'd1, 5'd3});
        cm_write(0, 6, 0, 1, {3'd2, 5'd5});
        cm_write(0, 0, 0, 1, {3'd3, 5'd31});
        cm_write(0, 1, 0, 1, {3'd4, 5'd31});
        cm_write(0, 31, 0, 1, {3'd5, 5'd30});
        cm_write(0, 7, 0, 1, {3'd6, 5'd7});
        check_frames("R3", 2);

        // R4: every channel of stream 2 broadcasts one source.
        for (int c = 0; c < NC; c++) cm_write(2, c, 0, 1, {3'd5, 5'd17});
        check_frames("R4", 2);

        // R5: message mode with random bytes everywhere.
        for (int i = 0; i < NS*NC; i++) cm_write(i / NC, i % NC, 1, 1, 8'($urandom));
        check_frames("R5", 2);

        // R6: mixed modes with random per-channel enables.
        for (int i = 0; i < NS*NC; i++)
            cm_write(i / NC, i % NC, 1'($urandom), 1'($urandom), 8'($urandom));
        check_frames("R6", 2);

        // R7: global output disable toggled at random each bit.
        rand_dis = 1;
        check_frames("R7", 2);
        rand_dis = 0;
        out_disable_n = 1'b1;

        // R8: global message-enable overrides stored flags that are all off.
        for (int i = 0; i < NS*NC; i++) cm_write(i / NC, i % NC, 0, 0, 8'($urandom));
        msg_all = 1'b1;
        check_frames("R8", 2);
        msg_all = 1'b0;
        check_frames("R8", 1);

        // R9: bit order and frame alignment patterns.
        cm_write(7, 0, 1, 1, 8'h80);
        cm_write(7, 31, 1, 1, 8'h01);
        cm_write(7, 1, 1, 1, 8'hA5);
        cm_write(6, 0, 0, 1, {3'd0, 5'd0});
        cm_write(6, 31, 0, 1, {3'd7, 5'd31});
        check_frames("R9", 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): ran %0d cycles, expected fewer", WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule